// File: doc/BRIEF.md
# Dual-Multiplier Binary-Field Arithmetic Core

This block is the arithmetic engine for one step of an elliptic-curve point multiplication over GF(2^M), with polynomial-basis operands and M = 163 by default. One start strobe launches two field multiplications at the same moment. Each multiplication works on its own pair of operands. When both products are ready, the block also registers their sum, the square of the first product and the square of that sum. A ladder-style point addition or doubling can therefore take two products, a sum and two squares from a single issue.

Both multipliers are bit-serial and take one operand bit per cycle, most significant bit first. They finish together after M cycles. The adder and the two squarers are combinational and sit behind the multipliers. All five results are captured into registers on the cycle of completion, and a one-cycle done pulse is raised at the same time. The reduction polynomial is a parameter. For M = 163 its low terms default to x^7 + x^6 + x^3 + 1, so wider fields only need the two parameters changed.

Top module: `ecc_dual_mult_core`

## Requirements
- R1: After reset, done is 0 and all five result outputs are 0.
- R2: prod0 equals a0·b0 and prod1 equals a1·b1, each reduced modulo x^163 + x^7 + x^6 + x^3 + 1. Bit i of every operand is the coefficient of x^i.
- R3: sum equals prod0 XOR prod1, which is field addition of the two products.
- R4: sq_prod equals prod0·prod0 reduced modulo the same polynomial.
- R5: sq_sum equals sum·sum reduced modulo the same polynomial.
- R6: done rises exactly M clock cycles after the edge that accepts start, and it stays high for exactly one cycle.
- R7: A start or an operand change while a multiplication is running has no effect: the results and the done timing follow the operands captured when start was accepted.
- R8: Between completions, all five outputs keep their values and done stays low.
- R9: A start raised in the cycle where done is high is accepted, so back-to-back issues have no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch both multiplications while idle |
| a0 | input | M | First operand of multiplier 0 |
| b0 | input | M | Second operand of multiplier 0 |
| a1 | input | M | First operand of multiplier 1 |
| b1 | input | M | Second operand of multiplier 1 |
| done | output | 1 | One-cycle pulse when results are updated |
| prod0 | output | M | a0·b0 mod f |
| prod1 | output | M | a1·b1 mod f |
| sum | output | M | prod0 + prod1 |
| sq_prod | output | M | prod0 squared mod f |
| sq_sum | output | M | sum squared mod f |

## Verification
The assertions check on every cycle that done is a single-cycle pulse arriving exactly M cycles after an accepted start, that no output moves except on a done cycle, and that the registered sum always matches the two registered products. The field values of the products and squares can only be confirmed by the bench scenarios. Those scenarios compare against an LSB-first reference multiplier on random operands and on the corner values 0, 1 and all-ones. The bench scenarios also cover restarts attempted mid-operation and issues made on the done cycle.

// File: rtl/ecc_dual_mult_core.sv
module ecc_dual_mult_core #(
  parameter int M = 163,
  parameter logic [M-1:0] RED = 'hC9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] a0,
  input  logic [M-1:0] b0,
  input  logic [M-1:0] a1,
  input  logic [M-1:0] b1,
  output logic         done,
  output logic [M-1:0] prod0,
  output logic [M-1:0] prod1,
  output logic [M-1:0] sum,
  output logic [M-1:0] sq_prod,
  output logic [M-1:0] sq_sum
);
  localparam int CW = $clog2(M);

  function automatic logic [M-1:0] xtime(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? RED : '0);
  endfunction

  function automatic logic [M-1:0] fsq(input logic [M-1:0] v);
    logic [2*M-2:0] t;
    t = '0;
    for (int i = 0; i < M; i++) t[2*i] = v[i];
    for (int i = 2*M-2; i >= M; i--) begin
      if (t[i]) begin
        t[i] = 1'b0;
        t[i-M +: M] = t[i-M +: M] ^ RED;
      end
    end
    return t[M-1:0];
  endfunction

  logic          busy;
  logic [CW-1:0] cnt;
  logic [M-1:0]  a0r, b0r, a1r, b1r, acc0, acc1;

  wire [M-1:0] nx0  = xtime(acc0) ^ (b0r[cnt] ? a0r : '0);
  wire [M-1:0] nx1  = xtime(acc1) ^ (b1r[cnt] ? a1r : '0);
  wire [M-1:0] nsum = nx0 ^ nx1;
  wire         last = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; done <= 1'b0;
      a0r <= '0; b0r <= '0; a1r <= '0; b1r <= '0;
      acc0 <= '0; acc1 <= '0;
      prod0 <= '0; prod1 <= '0; sum <= '0; sq_prod <= '0; sq_sum <= '0;
    end else begin
      done <= last;
      if (!busy) begin
        if (start) begin
          a0r <= a0; b0r <= b0; a1r <= a1; b1r <= b1;
          acc0 <= '0; acc1 <= '0;
          cnt <= CW'(M-1);
          busy <= 1'b1;
        end
      end else begin
        acc0 <= nx0;
        acc1 <= nx1;
        cnt  <= cnt - 1'b1;
        if (last) begin
          busy    <= 1'b0;
          prod0   <= nx0;
          prod1   <= nx1;
          sum     <= nsum;
          sq_prod <= fsq(nx0);
          sq_sum  <= fsq(nsum);
        end
      end
    end
  end
endmodule

module ecc_dual_mult_core_chk #(
  parameter int M = 163
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         done,
  input logic [M-1:0] prod0,
  input logic [M-1:0] prod1,
  input logic [M-1:0] sum,
  input logic [M-1:0] sq_prod,
  input logic [M-1:0] sq_sum
);
  logic        run;
  logic [31:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; age <= '0;
    end else if (start && (!run || done)) begin
      run <= 1'b1; age <= '0;
    end else if (done) begin
      run <= 1'b0;
    end else if (run) begin
      age <= age + 1;
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run && age == 32'(M)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(prod0) && $stable(prod1) && $stable(sum)
               && $stable(sq_prod) && $stable(sq_sum)));

  assert_sum_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sum == (prod0 ^ prod1));
endmodule

bind ecc_dual_mult_core ecc_dual_mult_core_chk #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .prod0(prod0), .prod1(prod1), .sum(sum), .sq_prod(sq_prod), .sq_sum(sq_sum)
);

// File: tb/test_ecc_dual_mult_core.sv
`timescale 1ns/1ps
module test_ecc_dual_mult_core;
  localparam int M = 163;
  localparam logic [M-1:0] LOWP = M'(8'hC9);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [M-1:0] a0 = '0, b0 = '0, a1 = '0, b1 = '0;
  logic done;
  logic [M-1:0] prod0, prod1, sum, sq_prod, sq_sum;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ecc_dual_mult_core #(.M(M)) i_ecc_dual_mult_core (
    .clk(clk), .rst_n(rst_n), .start(start), .a0(a0), .b0(b0), .a1(a1), .b1(b1),
    .done(done), .prod0(prod0), .prod1(prod1), .sum(sum),
    .sq_prod(sq_prod), .sq_sum(sq_sum)
  );

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [M-1:0] r, s;
    logic hi;
    r = '0; s = x;
    for (int i = 0; i < M; i++) begin
      if (y[i]) r = r ^ s;
      hi = s[M-1];
      s = s << 1;
      if (hi) s = s ^ LOWP;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] rnd();
    logic [191:0] w;
    for (int i = 0; i < 6; i++) w[i*32 +: 32] = $urandom;
    return w[M-1:0];
  endfunction

  task automatic chk(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Call at a negedge; returns at the negedge where done is seen high.
  task automatic issue(input logic [M-1:0] x0, input logic [M-1:0] y0,
                       input logic [M-1:0] x1, input logic [M-1:0] y1,
                       input int spam, input string tag);
    logic [M-1:0] p0, p1, s;
    int n;
    a0 = x0; b0 = y0; a1 = x1; b1 = y1; start = 1'b1;
    @(negedge clk);
    n = 0;
    for (int k = 0; k < spam; k++) begin
      a0 = rnd(); b0 = rnd(); a1 = rnd(); b1 = rnd(); start = 1'b1;
      if (done) break;
      @(negedge clk); n++;
    end
    start = 1'b0;
    while (!done && n < 2*M) begin
      @(negedge clk); n++;
    end
    p0 = ref_mul(x0, y0);
    p1 = ref_mul(x1, y1);
    s  = p0 ^ p1;
    chk_int({tag, " R6 latency"}, n, M);
    chk({tag, " R2 prod0"}, prod0, p0);
    chk({tag, " R2 prod1"}, prod1, p1);
    chk({tag, " R3 sum"}, sum, s);
    chk({tag, " R4 sq_prod"}, sq_prod, ref_mul(p0, p0));
    chk({tag, " R5 sq_sum"}, sq_sum, ref_mul(s, s));
  endtask

  task automatic idle_hold(input int cyc);
    logic [M-1:0] h0, h1, hs, hq, hr;
    h0 = prod0; h1 = prod1; hs = sum; hq = sq_prod; hr = sq_sum;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      chk_int("R6/R8 done low", int'(done), 0);
    end
    chk("R8 prod0 hold", prod0, h0);
    chk("R8 prod1 hold", prod1, h1);
    chk("R8 sum hold", sum, hs);
    chk("R8 sq_prod hold", sq_prod, hq);
    chk("R8 sq_sum hold", sq_sum, hr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [M-1:0] ones;
    ones = '1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk_int("R1 done", int'(done), 0);
    chk("R1 prod0", prod0, '0);
    chk("R1 prod1", prod1, '0);
    chk("R1 sum", sum, '0);
    chk("R1 sq_prod", sq_prod, '0);
    chk("R1 sq_sum", sq_sum, '0);
    rst_n = 1'b1;
    @(negedge clk);

    issue('0, rnd(), rnd(), '0, 0, "zero");
    idle_hold(4);
    issue(M'(1), rnd(), rnd(), M'(1), 0, "one");
    idle_hold(2);
    issue(ones, ones, ones, M'(1), 0, "allones");
    idle_hold(2);
    issue(ones, rnd(), M'(2), ones, 0, "mixed");
    idle_hold(2);

    // R7: restart attempts and operand changes while busy
    issue(rnd(), rnd(), rnd(), rnd(), 5, "R7 busy-start");
    idle_hold(2);
    issue(rnd(), rnd(), rnd(), rnd(), 40, "R7 long-spam");
    idle_hold(3);

    // R9: back-to-back issues on the done cycle
    issue(rnd(), rnd(), rnd(), rnd(), 0, "R9 first");
    issue(rnd(), rnd(), rnd(), rnd(), 0, "R9 second");
    issue(ones, ones, '0, ones, 0, "R9 third");
    @(negedge clk);
    chk_int("R6 single pulse", int'(done), 0);

    for (int t = 0; t < 25; t++) begin
      issue(rnd(), rnd(), rnd(), rnd(), 0, "random");
      if (t % 5 == 0) idle_hold(1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule